// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps a time of day and a calendar date in binary-coded decimal and advances them by one second each time a single-cycle tick arrives. It holds seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month, and year. The month byte also carries a century flag. The hours byte can use either a 24-hour encoding or a 12-hour encoding with a PM flag. The mode is chosen by a bit inside the hours byte.

A write port loads any one field per cycle, for use by a register interface. All seven fields are always visible on parallel outputs, so a host interface and an alarm comparator can read them directly. An oscillator and prescaler outside the block are assumed to produce the tick. The block does not check for impossible dates; if one is loaded, the behaviour that follows is unspecified.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset, the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 with the century flag clear, and year 0x00.
- R2: On each tick, seconds count in BCD from 0x00 to 0x59 and then wrap to 0x00. The wrap advances minutes, which count 0x00 to 0x59 in the same way. Minutes wrapping advances hours.
- R3: When hours bit 6 is 0 (24-hour mode), hours hold a BCD value from 0x00 to 0x23 in bits 5:0. The step from 0x23 to 0x00 marks midnight and advances the date fields.
- R4: When hours bit 6 is 1 (12-hour mode), bit 5 is the PM flag (1 = PM) and bits 4:0 hold 0x12, 0x01 to 0x11 in that order. The PM flag flips on the 11-to-12 step. Midnight is the step from 11 PM to 12 AM.
- R5: At midnight, the day of week advances by one and wraps from 0x07 to 0x01.
- R6: At midnight, the date advances to the month's last day and then returns to 0x01. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year's value is divisible by 4, and 28 days otherwise. All other months have 31 days.
- R7: Month bits 4:0 wrap from 0x12 to 0x01 and advance the year. The year wraps from 0x99 to 0x00, and that wrap toggles the century flag in month bit 7.
- R8: When the write strobe is high, the field chosen by the select code (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year) takes the write data on the next clock edge. Any tick in the same cycle is dropped, so no other field changes. Select code 7 changes nothing.
- R9: In a cycle with neither a tick nor a write, every field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | Value written to the selected field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours byte: mode bit 6, PM or tens-of-twenty bit 5, BCD below |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Century flag in bit 7, BCD month in bits 4:0 |
| year_o | output | 8 | Year, BCD |

## Verification
The hardest conditions to reach are the ones at the end of a chain of carries, such as the Dec 31 year-99 midnight that flips the century flag, or the 11 PM to 12 AM step in 12-hour mode. Counting up to them from reset would take far too many seconds. The stimulus instead writes each field to a value a few seconds before the boundary and then issues ticks across it. It does this once for each month length, for leap and non-leap Februaries, and for both hour encodings. Between the preset cases, a long tick run with gaps between ticks covers the ordinary counting.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    localparam int FIELD_W = 8;
    localparam int SEL_W   = 3;

    typedef logic [FIELD_W-1:0] bcd_byte_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } field_sel_e;

    typedef struct packed {
        bcd_byte_t sec;
        bcd_byte_t min;
        bcd_byte_t hour;
        bcd_byte_t dow;
        bcd_byte_t date;
        bcd_byte_t month;
        bcd_byte_t year;
    } cal_state_t;

    localparam cal_state_t CAL_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, month: 8'h01, year: 8'h00
    };

    localparam int HOUR_MODE_BIT = 6;
    localparam int HOUR_PM_BIT   = 5;
    localparam int CENTURY_BIT   = 7;

    // Add one to a two-digit BCD value without range wrap.
    function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when the BCD year is a multiple of four.
    function automatic logic bcd_leap(input bcd_byte_t y);
        logic [7:0] bin;
        bin = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    // Last day of a BCD month, given the BCD year.
    function automatic bcd_byte_t month_last_day(input logic [4:0] m, input bcd_byte_t y);
        case (m)
            5'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_time_step.sv
module cal_time_step
    import bcd_calendar_pkg::*;
(
    input  bcd_byte_t sec_i,
    input  bcd_byte_t min_i,
    input  bcd_byte_t hour_i,
    output bcd_byte_t sec_n,
    output bcd_byte_t min_n,
    output bcd_byte_t hour_n,
    output logic      day_step
);
    logic      sec_wrap;
    logic      min_wrap;
    logic      mode12;
    logic      pm;
    logic [4:0] h12;
    bcd_byte_t hour_adv;
    logic      hour_wrap;

    assign sec_wrap = (sec_i == 8'h59);
    assign min_wrap = (min_i == 8'h59);
    assign mode12   = hour_i[HOUR_MODE_BIT];
    assign pm       = hour_i[HOUR_PM_BIT];
    assign h12      = hour_i[4:0];

    always_comb begin
        hour_adv  = hour_i;
        hour_wrap = 1'b0;
        if (mode12) begin
            if (h12 == 5'h12) begin
                hour_adv = {2'b01, pm, 5'h01};
            end else if (h12 == 5'h11) begin
                hour_adv  = {2'b01, ~pm, 5'h12};
                hour_wrap = pm;
            end else begin
                hour_adv = {2'b01, pm, 5'(bcd_inc({3'b000, h12}))};
            end
        end else begin
            if (hour_i[5:0] == 6'h23) begin
                hour_adv  = 8'h00;
                hour_wrap = 1'b1;
            end else begin
                hour_adv = {2'b00, 6'(bcd_inc({2'b00, hour_i[5:0]}))};
            end
        end
    end

    assign sec_n    = sec_wrap ? 8'h00 : bcd_inc(sec_i);
    assign min_n    = sec_wrap ? (min_wrap ? 8'h00 : bcd_inc(min_i)) : min_i;
    assign hour_n   = (sec_wrap && min_wrap) ? hour_adv : hour_i;
    assign day_step = sec_wrap && min_wrap && hour_wrap;

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
    import bcd_calendar_pkg::*;
(
    input  logic      day_step,
    input  bcd_byte_t dow_i,
    input  bcd_byte_t date_i,
    input  bcd_byte_t month_i,
    input  bcd_byte_t year_i,
    output bcd_byte_t dow_n,
    output bcd_byte_t date_n,
    output bcd_byte_t month_n,
    output bcd_byte_t year_n
);
    logic       month_end;
    logic       year_end;
    logic       century;
    logic [4:0] mon;

    assign mon       = month_i[4:0];
    assign century   = month_i[CENTURY_BIT];
    assign month_end = (date_i == month_last_day(mon, year_i));
    assign year_end  = month_end && (mon == 5'h12);

    always_comb begin
        dow_n   = dow_i;
        date_n  = date_i;
        month_n = month_i;
        year_n  = year_i;
        if (day_step) begin
            dow_n  = (dow_i == 8'h07) ? 8'h01 : dow_i + 8'd1;
            date_n = month_end ? 8'h01 : bcd_inc(date_i);
            if (year_end) begin
                if (year_i == 8'h99) begin
                    year_n  = 8'h00;
                    month_n = {~century, 2'b00, 5'h01};
                end else begin
                    year_n  = bcd_inc(year_i);
                    month_n = {century, 2'b00, 5'h01};
                end
            end else if (month_end) begin
                month_n = {century, 2'b00, 5'(bcd_inc({3'b000, mon}))};
            end
        end
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_calendar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [FIELD_W-1:0]  wr_data,
    output logic [FIELD_W-1:0]  sec_o,
    output logic [FIELD_W-1:0]  min_o,
    output logic [FIELD_W-1:0]  hour_o,
    output logic [FIELD_W-1:0]  dow_o,
    output logic [FIELD_W-1:0]  date_o,
    output logic [FIELD_W-1:0]  month_o,
    output logic [FIELD_W-1:0]  year_o
);
    cal_state_t cal_q;
    cal_state_t cal_adv;
    logic       day_step;

    cal_time_step u_time (
        .sec_i    (cal_q.sec),
        .min_i    (cal_q.min),
        .hour_i   (cal_q.hour),
        .sec_n    (cal_adv.sec),
        .min_n    (cal_adv.min),
        .hour_n   (cal_adv.hour),
        .day_step (day_step)
    );

    cal_date_step u_date (
        .day_step (day_step),
        .dow_i    (cal_q.dow),
        .date_i   (cal_q.date),
        .month_i  (cal_q.month),
        .year_i   (cal_q.year),
        .dow_n    (cal_adv.dow),
        .date_n   (cal_adv.date),
        .month_n  (cal_adv.month),
        .year_n   (cal_adv.year)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= CAL_RESET;
        end else if (wr_en) begin
            case (field_sel_e'(wr_sel))
                FLD_SEC:   cal_q.sec   <= wr_data;
                FLD_MIN:   cal_q.min   <= wr_data;
                FLD_HOUR:  cal_q.hour  <= wr_data;
                FLD_DOW:   cal_q.dow   <= wr_data;
                FLD_DATE:  cal_q.date  <= wr_data;
                FLD_MONTH: cal_q.month <= wr_data;
                FLD_YEAR:  cal_q.year  <= wr_data;
                default:   ;
            endcase
        end else if (tick) begin
            cal_q <= cal_adv;
        end
    end

    assign sec_o   = cal_q.sec;
    assign min_o   = cal_q.min;
    assign hour_o  = cal_q.hour;
    assign dow_o   = cal_q.dow;
    assign date_o  = cal_q.date;
    assign month_o = cal_q.month;
    assign year_o  = cal_q.year;

    assert_reset_values_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
                                dow_o == 8'h01 && date_o == 8'h01 && month_o == 8'h01 && year_o == 8'h00));

    assert_minute_holds_R2: assert property (@(posedge clk) disable iff (rst)
        tick && !wr_en && sec_o != 8'h59 |=> $stable(min_o) && $stable(hour_o));

    assert_dow_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        tick && !wr_en && day_step && dow_o == 8'h07 |=> dow_o == 8'h01);

    assert_century_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        tick && !wr_en && day_step && month_o[4:0] == 5'h12 && date_o == 8'h31 && year_o == 8'h99
        |=> year_o == 8'h00 && month_o[CENTURY_BIT] != $past(month_o[CENTURY_BIT]));

    assert_write_no_carry_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 3'd0 |=> $stable(min_o) && $stable(hour_o) && $stable(date_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !tick && !wr_en |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                            $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o));

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference state (plain integers)
    int m_sec, m_min, m_h24, m_mode12, m_dow, m_date, m_mon, m_cent, m_year;

    always #5 clk = ~clk;

    bcd_calendar i_bcd_calendar (
        .clk, .rst, .tick, .wr_en, .wr_sel, .wr_data,
        .sec_o, .min_o, .hour_o, .dow_o, .date_o, .month_o, .year_o
    );

    function automatic int to_bcd(int n);
        return (n / 10) * 16 + (n % 10);
    endfunction

    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    function automatic int days_of(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int hour_byte();
        int h;
        if (m_mode12 == 0) return to_bcd(m_h24);
        h = m_h24 % 12;
        if (h == 0) h = 12;
        return 'h40 + ((m_h24 >= 12) ? 'h20 : 0) + to_bcd(h);
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_h24 = 0; m_mode12 = 0;
        m_dow = 1; m_date = 1; m_mon = 1; m_cent = 0; m_year = 0;
    endtask

    task automatic model_tick();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_h24++;
        if (m_h24 < 24) return;
        m_h24 = 0;
        m_dow = (m_dow % 7) + 1;
        m_date++;
        if (m_date <= days_of(m_mon, m_year)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_year++;
        if (m_year < 100) return;
        m_year = 0; m_cent = 1 - m_cent;
    endtask

    task automatic model_write(int sel, int b);
        int h;
        case (sel)
            0: m_sec = from_bcd(b);
            1: m_min = from_bcd(b);
            2: begin
                m_mode12 = (b / 64) % 2;
                if (m_mode12 == 1) begin
                    h = from_bcd(b % 32);
                    m_h24 = (h % 12) + (((b / 32) % 2 == 1) ? 12 : 0);
                end else begin
                    m_h24 = from_bcd(b % 64);
                end
            end
            3: m_dow = b;
            4: m_date = from_bcd(b);
            5: begin m_cent = b / 128; m_mon = from_bcd(b % 32); end
            6: m_year = from_bcd(b);
            default: ;
        endcase
    endtask

    task automatic cmp(string tag, string name, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, name, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        checks++;
        cmp(tag, "sec", sec_o, to_bcd(m_sec));
        cmp(tag, "min", min_o, to_bcd(m_min));
        cmp(tag, "hour", hour_o, hour_byte());
        cmp(tag, "dow", dow_o, m_dow);
        cmp(tag, "date", date_o, to_bcd(m_date));
        cmp(tag, "month", month_o, m_cent * 128 + to_bcd(m_mon));
        cmp(tag, "year", year_o, to_bcd(m_year));
    endtask

    // one clock: drive at negedge, update model, compare after the edge
    task automatic step(string tag, bit t, bit w, int sel, int data);
        @(negedge clk);
        tick = t; wr_en = w; wr_sel = 3'(sel); wr_data = 8'(data);
        if (w) model_write(sel, data);
        else if (t) model_tick();
        @(posedge clk);
        #2;
        tick = 1'b0; wr_en = 1'b0;
        compare_all(tag);
    endtask

    task automatic wr(string tag, int sel, int data);
        step(tag, 1'b0, 1'b1, sel, data);
    endtask

    task automatic ticks(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 0, 0);
    endtask

    task automatic preset(string tag, int hr, int mi, int se, int dw, int dt, int mo, int yr);
        wr(tag, 2, hr); wr(tag, 1, mi); wr(tag, 0, se);
        wr(tag, 3, dw); wr(tag, 4, dt); wr(tag, 5, mo); wr(tag, 6, yr);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        compare_all("R1");

        ticks("R2", 125);
        step("R9", 1'b0, 1'b0, 0, 0);
        step("R9", 1'b0, 1'b0, 0, 0);

        // 24-hour midnight with day-of-week 7 wrap
        preset("R3", 'h23, 'h59, 'h57, 7, 'h14, 'h03, 'h21);
        ticks("R5", 5);

        // 12-hour: 11 AM -> 12 PM, then 12 -> 01
        preset("R4", 'h51, 'h59, 'h58, 2, 'h05, 'h06, 'h10);
        ticks("R4", 4);
        wr("R4", 1, 'h59); wr("R4", 0, 'h58);
        ticks("R4", 3);
        // 12-hour: 11 PM -> 12 AM midnight
        preset("R4", 'h71, 'h59, 'h58, 3, 'h05, 'h06, 'h10);
        ticks("R4", 4);

        // month lengths
        preset("R6", 'h23, 'h59, 'h59, 1, 'h28, 'h02, 'h24);
        ticks("R6", 1); wr("R6", 1, 'h59); wr("R6", 2, 'h23); wr("R6", 0, 'h59);
        ticks("R6", 1);
        preset("R6", 'h23, 'h59, 'h59, 1, 'h28, 'h02, 'h23);
        ticks("R6", 2);
        preset("R6", 'h23, 'h59, 'h59, 1, 'h30, 'h04, 'h23);
        ticks("R6", 2);
        preset("R6", 'h23, 'h59, 'h59, 1, 'h30, 'h08, 'h23);
        ticks("R6", 2);

        // year and century rollover, twice
        preset("R7", 'h23, 'h59, 'h58, 5, 'h31, 'h12, 'h99);
        ticks("R7", 3);
        preset("R7", 'h23, 'h59, 'h59, 5, 'h31, 'h92, 'h99);
        ticks("R7", 2);
        preset("R7", 'h23, 'h59, 'h59, 5, 'h31, 'h12, 'h41);
        ticks("R7", 2);

        // write with simultaneous tick, and unused select
        preset("R8", 'h10, 'h59, 'h59, 4, 'h10, 'h05, 'h30);
        step("R8", 1'b1, 1'b1, 0, 'h59);
        step("R8", 1'b1, 1'b1, 7, 'h33);
        step("R8", 1'b0, 1'b1, 7, 'h44);
        ticks("R8", 2);

        // long run with gaps, in 12-hour mode
        preset("R2", 'h68, 'h45, 'h00, 6, 'h27, 'h02, 'h32);
        for (int i = 0; i < 12000; i++) step("R2", (i % 3) != 0, 1'b0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule